// File: doc/BRIEF.md
# Endpoint FIFO Access Controller

This block lets a microcontroller move bytes between its register bus and three small USB endpoint FIFOs. Firmware talks to it through one shared command/status byte and three data-window addresses. The command/status byte selects an endpoint and a direction and carries a request bit. It also holds a flush command, two sticky event flags raised by the host side, and a read-only ready flag. Each FIFO also has a host-side push/pop port. In a full system the serial interface engine drives that port; here a stub does.

A transfer is a fixed handshake. Firmware writes the select and direction, then raises the request bit and polls until the ready flag reads as 1. It then moves a single byte through the matching data window and, once done, flips the direction bit and drops the request. After every accepted byte access the ready flag is held low for a settle interval of `SETTLE_CYC` core clocks. Data-window accesses that do not meet the handshake are ignored.

Top module: `ep_fifo_access`

## Requirements
- R1: After `rst_ni` is released, and in the cycle after `bus_rst_i` is high, the command/status byte reads 00h. A bus reset wins over a command/status write or a host flag event in the same cycle.
- R2: The command/status byte at `CSR_ADDR` (default 46h) reads as bit0 request, bit1 direction (1 = firmware writes to the FIFO), bit2 flush, bits4:3 endpoint select, bit5 setup flag, bit6 ready, bit7 zero-length flag. Bits 4:0 read back the value last written.
- R3: Ready reads 1 only when all of these hold: request is 1, the select is 00, 01 or 10, the settle timer is idle, and the selected FIFO is non-empty (direction 0) or not full (direction 1). Select 11 is reserved and never gives ready.
- R4: A read of data window `WIN_BASE`+select (defaults 48h, 49h, 4Ah for endpoints 0, 1, 2) with request 1, direction 0 and ready 1 returns the oldest byte of that FIFO and removes it. Any other window read returns 00h and removes nothing.
- R5: A write to data window `WIN_BASE`+select with request 1, direction 1 and ready 1 appends the byte to the selected FIFO. Any other window write is ignored.
- R6: After an accepted window access, ready reads 0 for exactly `SETTLE_CYC` clock cycles and then returns if R3 still holds.
- R7: A command/status write with bit2 set empties the FIFO named by bits4:3 of the written value, whatever the ready flag and request bit are; the other FIFOs keep their contents.
- R8: A `host_setup_i` pulse sets the setup flag (bit5) and a `host_zlp_i` pulse sets the zero-length flag (bit7). Each flag stays set until firmware writes 1 to that bit; writing 0 leaves it alone. A host event in the same cycle as the clearing write leaves the flag set.
- R9: When a firmware window access and a host access hit the same FIFO in the same direction in one cycle, only the firmware access is performed.
- R10: Each FIFO holds `DEPTH` bytes (default 8) in arrival order. `host_empty_o` and `host_full_o` report its state, `host_rdata_o` shows the oldest byte, and a host push to a full FIFO or a pop from an empty one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | USB bus reset, clears the command/status byte synchronously |
| reg_addr_i | input | 8 | Register bus address |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, valid in the cycle of the read strobe |
| host_push_i | input | 3 | Host-side push, one bit per endpoint |
| host_wdata_i | input | 8 | Host-side push data |
| host_pop_i | input | 3 | Host-side pop, one bit per endpoint |
| host_rdata_o | output | 24 | Oldest byte of each FIFO, endpoint k at bits 8k+7:8k |
| host_empty_o | output | 3 | FIFO empty flags |
| host_full_o | output | 3 | FIFO full flags |
| host_setup_i | input | 1 | SETUP packet received pulse |
| host_zlp_i | input | 1 | Zero-length OUT packet received pulse |

## Verification
Two functions can meet in the same cycle. A host event can raise the setup or zero-length flag in the same cycle that firmware writes 1 to clear that flag. Separately, a firmware window write and a host push can reach the same FIFO in the same cycle. The bench drives each pair on the same clock edge. It then judges the outcome from the command/status read-back: the flag must still be set. For the FIFO pair it judges from the host-side pop stream and empty flag: only the firmware byte may be present. Bus reset coinciding with a command/status write is provoked the same way, and the register must read 00h afterwards.

// File: rtl/epf_pkg.sv
package epf_pkg;
  localparam int NUM_EP = 3;
  localparam int DW     = 8;
  localparam int SELW   = 2;
  localparam logic [SELW-1:0] SEL_RSVD = 2'b11;

  // bit positions inside the command/status byte
  localparam int B_REQ   = 0;
  localparam int B_TX    = 1;
  localparam int B_CLR   = 2;
  localparam int B_SEL0  = 3;
  localparam int B_SEL1  = 4;
  localparam int B_SETUP = 5;
  localparam int B_RDY   = 6;
  localparam int B_ZLP   = 7;
endpackage

// File: rtl/epf_fifo.sv
module epf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic          flush_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLC);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(wptr_q)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o && $stable(rptr_q)); // R10
endmodule

// File: rtl/epf_pace.sv
module epf_pace #(
  parameter int CYC = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clr_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (start_i)     cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !clr_i |=> busy_o); // R6
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !start_i && !clr_i |=> cnt_q == $past(cnt_q) - 1'b1); // R6
endmodule

// File: rtl/epf_csr.sv
module epf_csr
  import epf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_rst_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            setup_evt_i,
  input  logic            zlp_evt_i,
  output logic            req_o,
  output logic            tx_o,
  output logic            clr_o,
  output logic [SELW-1:0] sel_o,
  output logic            setup_o,
  output logic            zlp_o
);
  logic            req_q, tx_q, clr_q, setup_q, zlp_q;
  logic [SELW-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; tx_q <= 1'b0; clr_q <= 1'b0;
      sel_q <= '0;   setup_q <= 1'b0; zlp_q <= 1'b0;
    end else if (bus_rst_i) begin
      req_q <= 1'b0; tx_q <= 1'b0; clr_q <= 1'b0;
      sel_q <= '0;   setup_q <= 1'b0; zlp_q <= 1'b0;
    end else begin
      if (wr_i) begin
        req_q <= wdata_i[B_REQ];
        tx_q  <= wdata_i[B_TX];
        clr_q <= wdata_i[B_CLR];
        sel_q <= {wdata_i[B_SEL1], wdata_i[B_SEL0]};
      end
      // host set beats firmware write-one-to-clear
      setup_q <= setup_evt_i | (setup_q & ~(wr_i & wdata_i[B_SETUP]));
      zlp_q   <= zlp_evt_i   | (zlp_q   & ~(wr_i & wdata_i[B_ZLP]));
    end
  end

  assign req_o   = req_q;
  assign tx_o    = tx_q;
  assign clr_o   = clr_q;
  assign sel_o   = sel_q;
  assign setup_o = setup_q;
  assign zlp_o   = zlp_q;

  AST_BUS_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> !req_o && !tx_o && !clr_o && sel_o == '0 && !setup_o && !zlp_o); // R1
  AST_SETUP_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_evt_i && !bus_rst_i |=> setup_o); // R8
  AST_ZLP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zlp_o && !bus_rst_i && !(wr_i && wdata_i[B_ZLP]) |=> zlp_o); // R8
endmodule

// File: rtl/ep_fifo_access.sv
module ep_fifo_access
  import epf_pkg::*;
#(
  parameter int          DEPTH      = 8,
  parameter int          SETTLE_CYC = 96,
  parameter logic [7:0]  CSR_ADDR   = 8'h46,
  parameter logic [7:0]  WIN_BASE   = 8'h48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_rst_i,
  input  logic [7:0]           reg_addr_i,
  input  logic                 reg_we_i,
  input  logic                 reg_re_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  input  logic [NUM_EP-1:0]    host_push_i,
  input  logic [DW-1:0]        host_wdata_i,
  input  logic [NUM_EP-1:0]    host_pop_i,
  output logic [NUM_EP*DW-1:0] host_rdata_o,
  output logic [NUM_EP-1:0]    host_empty_o,
  output logic [NUM_EP-1:0]    host_full_o,
  input  logic                 host_setup_i,
  input  logic                 host_zlp_i
);
  logic            req, tx, clr_bit, setup_f, zlp_f;
  logic [SELW-1:0] sel;
  logic            csr_wr, csr_rd, sel_valid, win_hit, busy, ready;
  logic            sel_empty, sel_full, fw_rd_ok, fw_wr_ok, flush_wr;
  logic [DW-1:0]   head [NUM_EP];
  logic [DW-1:0]   sel_head, csr_byte;
  logic [NUM_EP-1:0] empty_v, full_v;

  assign csr_wr    = reg_we_i && (reg_addr_i == CSR_ADDR);
  assign csr_rd    = reg_re_i && (reg_addr_i == CSR_ADDR);
  assign sel_valid = (sel != SEL_RSVD);
  assign win_hit   = sel_valid && (reg_addr_i == WIN_BASE + 8'(sel));
  assign flush_wr  = csr_wr && reg_wdata_i[B_CLR];

  epf_csr u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_i  (bus_rst_i),
    .wr_i       (csr_wr),
    .wdata_i    (reg_wdata_i),
    .setup_evt_i(host_setup_i),
    .zlp_evt_i  (host_zlp_i),
    .req_o      (req),
    .tx_o       (tx),
    .clr_o      (clr_bit),
    .sel_o      (sel),
    .setup_o    (setup_f),
    .zlp_o      (zlp_f)
  );

  epf_pace #(.CYC(SETTLE_CYC)) u_pace (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(fw_rd_ok || fw_wr_ok),
    .clr_i  (bus_rst_i),
    .busy_o (busy)
  );

  always_comb begin
    sel_empty = 1'b1;
    sel_full  = 1'b1;
    sel_head  = '0;
    for (int k = 0; k < NUM_EP; k++) begin
      if (sel == SELW'(k)) begin
        sel_empty = empty_v[k];
        sel_full  = full_v[k];
        sel_head  = head[k];
      end
    end
  end

  assign ready    = req && sel_valid && !busy && (tx ? !sel_full : !sel_empty);
  assign fw_rd_ok = reg_re_i && win_hit && req && !tx && ready;
  assign fw_wr_ok = reg_we_i && win_hit && req &&  tx && ready;

  assign csr_byte = {zlp_f, ready, setup_f, sel, clr_bit, tx, req};

  always_comb begin
    if (csr_rd)        reg_rdata_o = csr_byte;
    else if (fw_rd_ok) reg_rdata_o = sel_head;
    else               reg_rdata_o = '0;
  end

  for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
    logic hit_sel, fw_push, fw_pop;
    assign hit_sel = (sel == SELW'(k));
    assign fw_push = fw_wr_ok && hit_sel;
    assign fw_pop  = fw_rd_ok && hit_sel;

    epf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (fw_push || host_push_i[k]),
      .wdata_i(fw_push ? reg_wdata_i : host_wdata_i),
      .pop_i  (fw_pop || host_pop_i[k]),
      .flush_i(flush_wr && ({reg_wdata_i[B_SEL1], reg_wdata_i[B_SEL0]} == SELW'(k))),
      .rdata_o(head[k]),
      .empty_o(empty_v[k]),
      .full_o (full_v[k])
    );

    assign host_rdata_o[k*DW +: DW] = head[k];
  end

  assign host_empty_o = empty_v;
  assign host_full_o  = full_v;

  AST_ACCESS_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_rd_ok || fw_wr_ok) |=> !ready); // R6
  AST_RSVD_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_RSVD) |-> !ready); // R3
  AST_RD_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_rd_ok |-> !sel_empty && !busy); // R4
endmodule

// File: tb/sim_ep_fifo_access.sv
`timescale 1ns/1ps
module sim_ep_fifo_access;
  localparam int ST  = 8;
  localparam int DEP = 8;
  localparam logic [7:0] CSR = 8'h46;
  localparam logic [7:0] WB  = 8'h48;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_rst = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic [2:0]  host_push = '0, host_pop = '0;
  logic [7:0]  host_wdata = '0;
  logic [23:0] host_rdata;
  logic [2:0]  host_empty, host_full;
  logic        host_setup = 1'b0, host_zlp = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_d;
  string      mon_tag;
  event       mon_ev;

  always #2.5 clk = ~clk;

  ep_fifo_access #(.DEPTH(DEP), .SETTLE_CYC(ST), .CSR_ADDR(CSR), .WIN_BASE(WB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_rst_i(bus_rst),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .host_push_i(host_push), .host_wdata_i(host_wdata), .host_pop_i(host_pop),
    .host_rdata_o(host_rdata), .host_empty_o(host_empty), .host_full_o(host_full),
    .host_setup_i(host_setup), .host_zlp_i(host_zlp)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(mon_ev);
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s actual=%02h expected=<none>", mon_tag, mon_d);
    end else begin
      check(mon_tag, mon_d, exp_q.pop_front());
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_wr(logic [7:0] v);
    reg_addr = CSR; reg_wdata = v; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_csr(string tag, logic [7:0] e);
    logic [7:0] v;
    reg_addr = CSR; reg_re = 1'b1;
    #1 v = reg_rdata;
    reg_re = 1'b0;
    check(tag, v, e);
  endtask

  task automatic win_rd(int idx, output logic [7:0] v);
    reg_addr = WB + 8'(idx); reg_re = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic fw_read_sb(int idx, string tag);
    logic [7:0] v;
    win_rd(idx, v);
    mon_d = v; mon_tag = tag; ->mon_ev;
  endtask

  task automatic win_wr(int idx, logic [7:0] d, bit sb);
    reg_addr = WB + 8'(idx); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (sb) exp_q.push_back(d);
  endtask

  task automatic hpush(int k, logic [7:0] d, bit sb);
    host_push[k] = 1'b1; host_wdata = d;
    @(negedge clk);
    host_push = '0;
    if (sb) exp_q.push_back(d);
  endtask

  task automatic hpop_sb(int k, string tag);
    logic [7:0] v;
    host_pop[k] = 1'b1;
    #1 v = host_rdata[k*8 +: 8];
    @(negedge clk);
    host_pop = '0;
    mon_d = v; mon_tag = tag; ->mon_ev;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    tick(3);
    rst_ni = 1'b1;
    tick();
    chk_csr("R1 after reset", 8'h00);

    // read sequence from endpoint 0
    hpush(0, 8'hA1, 1); hpush(0, 8'hB2, 1); hpush(0, 8'hC3, 1);
    csr_wr(8'h00); csr_wr(8'h01);
    chk_csr("R3 ready on read request", 8'h41);
    fw_read_sb(0, "R4 first byte");
    chk_csr("R6 ready low after access", 8'h01);
    tick(ST - 1);
    chk_csr("R6 still settling", 8'h01);
    tick();
    chk_csr("R6 ready back", 8'h41);
    fw_read_sb(0, "R4 second byte");
    tick(ST);
    fw_read_sb(0, "R10 order third byte");
    tick(ST);
    chk_csr("R3 empty no ready", 8'h01);
    csr_wr(8'h03);
    chk_csr("R2 tx readback", 8'h43);
    csr_wr(8'h02);
    chk_csr("R2 request dropped", 8'h02);

    // ignored reads
    hpush(0, 8'hD4, 1);
    win_rd(0, v); check("R4 read without request", v, 8'h00);
    csr_wr(8'h00);
    win_rd(0, v); check("R4 read idle", v, 8'h00);
    csr_wr(8'h01);
    chk_csr("R4 byte not consumed", 8'h41);
    win_rd(1, v); check("R4 wrong window", v, 8'h00);
    chk_csr("R4 wrong window no effect", 8'h41);
    fw_read_sb(0, "R4 byte kept");
    tick(ST);
    csr_wr(8'h00);

    // write sequence to endpoint 1
    csr_wr(8'h0A); csr_wr(8'h0B);
    chk_csr("R3 ready on write request", 8'h4B);
    win_wr(1, 8'h5A, 1);
    chk_csr("R6 ready low after write", 8'h0B);
    tick(ST);
    chk_csr("R6 write ready back", 8'h4B);
    win_wr(1, 8'h6B, 1);
    tick(ST);
    win_wr(0, 8'h99, 0);
    csr_wr(8'h09);
    chk_csr("R5 two bytes stored", 8'h49);
    csr_wr(8'h08);
    win_wr(1, 8'h77, 0);
    hpop_sb(1, "R5 first written byte");
    hpop_sb(1, "R5 second written byte");
    check("R5 ignored writes left fifo empty", {7'd0, host_empty[1]}, 8'h01);

    // fill endpoint 2
    csr_wr(8'h10); csr_wr(8'h13);
    chk_csr("R3 ready endpoint 2", 8'h53);
    for (int i = 0; i < DEP; i++) begin
      win_wr(2, 8'h20 + 8'(i), 1);
      tick(ST);
    end
    chk_csr("R3 full no ready", 8'h13);
    win_wr(2, 8'hEE, 0);
    check("R10 full flag", {7'd0, host_full[2]}, 8'h01);
    csr_wr(8'h11);
    chk_csr("R3 read mode on full fifo", 8'h51);
    csr_wr(8'h10);
    for (int i = 0; i < DEP; i++) hpop_sb(2, "R10 host pop order");
    check("R10 empty after drain", {7'd0, host_empty[2]}, 8'h01);

    // reserved select
    csr_wr(8'h19);
    chk_csr("R3 reserved read", 8'h19);
    csr_wr(8'h1B);
    chk_csr("R3 reserved write", 8'h1B);
    csr_wr(8'h00);

    // flush
    hpush(2, 8'h11, 0); hpush(2, 8'h22, 0); hpush(0, 8'h33, 0);
    csr_wr(8'h14);
    check("R7 selected fifo flushed", {7'd0, host_empty[2]}, 8'h01);
    check("R7 other fifo kept", {7'd0, host_empty[0]}, 8'h00);
    chk_csr("R2 flush bit readback", 8'h14);
    csr_wr(8'h01);
    chk_csr("R3 ready before flush", 8'h41);
    csr_wr(8'h05);
    chk_csr("R7 flush while ready", 8'h05);
    csr_wr(8'h00);

    // setup flag
    host_setup = 1'b1; tick(); host_setup = 1'b0;
    chk_csr("R8 setup set", 8'h20);
    csr_wr(8'h01);
    chk_csr("R8 setup survives write of 0", 8'h21);
    csr_wr(8'h20);
    chk_csr("R8 setup cleared by 1", 8'h00);

    // zero-length flag
    host_zlp = 1'b1; tick(); host_zlp = 1'b0;
    csr_wr(8'h00); csr_wr(8'h01);
    chk_csr("R8 zero-length read status", 8'h81);
    csr_wr(8'h80);
    chk_csr("R8 zero-length cleared", 8'h00);
    host_zlp = 1'b1;
    csr_wr(8'h80);
    host_zlp = 1'b0;
    chk_csr("R8 host set beats clear", 8'h80);
    host_setup = 1'b1;
    csr_wr(8'hA0);
    host_setup = 1'b0;
    chk_csr("R8 setup set beats clear, zlp cleared", 8'h20);
    csr_wr(8'h20);

    // same-cycle firmware and host push
    csr_wr(8'h0B);
    chk_csr("R9 ready before collision", 8'h4B);
    host_push[1] = 1'b1; host_wdata = 8'hC0;
    reg_addr = WB + 8'd1; reg_wdata = 8'h5C; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; host_push = '0;
    exp_q.push_back(8'h5C);
    csr_wr(8'h08);
    hpop_sb(1, "R9 firmware byte wins");
    check("R9 host byte dropped", {7'd0, host_empty[1]}, 8'h01);

    // bus reset
    csr_wr(8'h0B);
    bus_rst = 1'b1; tick(); bus_rst = 1'b0;
    chk_csr("R1 bus reset", 8'h00);
    bus_rst = 1'b1; host_zlp = 1'b1;
    csr_wr(8'h01);
    bus_rst = 1'b0; host_zlp = 1'b0;
    chk_csr("R1 bus reset beats write", 8'h00);

    check("R10 scoreboard drained", 8'(exp_q.size()), 8'h00);
    tick(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule